// File: doc/BRIEF.md
# Clock Synthesizer Serial Program Receiver

This block sits on the synthesizer side of a two-wire programming link. It watches a slow programming clock line and a data line that a host toggles by software, oversamples both with the local system clock, and rebuilds the 24-bit programming words the host sends. Synthesis of the frequency is done elsewhere. This block only keeps the programmed values and reports when a word has landed.

The receiver starts locked. A host must first send an unlock preamble, then a start bit, then 24 bits in a Manchester-like code, then a stop bit. A bit is valid only when the data level at the clock's falling edge is the inverse of the level at the next rising edge. A good word carries a 3-bit slot number and four fields: an index, a feedback divider N, a post-scaler P and a reference divider D. These fields are written into the chosen slot, and a one-cycle load strobe reports the slot number. A bad word is dropped and raises a sticky error flag. After any word, good or bad, the receiver locks again.

Top module: `clksyn_prog_rx`

## Requirements
- R1: After reset, every slot field reads zero, `err_o` and `load_o` are low, and the receiver is locked.
- R2: The receiver unlocks only after at least five consecutive programming-clock rising edges with data high, followed by a rising edge with data low. With fewer high edges, the words that follow are not stored and no output changes.
- R3: Once unlocked, the next rising edge with data low starts a frame. If data is high at that edge, no frame starts and the receiver locks again.
- R4: A data bit is the data level at a programming-clock rising edge. Bits arrive least significant first, and 24 bits form one word.
- R5: If the data level at the falling edge before a bit's rising edge equals that bit's value, the word is discarded, `err_o` is set and the receiver locks.
- R6: After the 24th bit, a rising edge with data high completes the word. Data low at that edge discards the word, sets `err_o` and locks the receiver.
- R7: The word is decoded as follows: bits 23:21 give the slot number, 20:17 the index, 16:10 N, 9:7 P and 6:0 D. Slot k appears at bits [k*W +: W] of each slot output, where W is the field width.
- R8: A stored word gives exactly one cycle of `load_o`, with `load_sel_o` equal to the slot number. The new slot contents are visible in that same cycle, and the receiver is locked again.
- R9: `err_o` stays high until reset. Valid words sent after an error are still stored.
- R10: Writing a word changes only the addressed slot, and slot contents change only in a cycle where `load_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_clk_i | input | 1 | Programming clock line, asynchronous |
| prog_data_i | input | 1 | Programming data line, asynchronous |
| load_o | output | 1 | One-cycle strobe when a word is stored |
| load_sel_o | output | 3 | Slot number of the last stored word |
| err_o | output | 1 | Sticky framing or coding error |
| slot_idx_o | output | 32 | Index field of all 8 slots, 4 bits each |
| slot_n_o | output | 56 | N field of all 8 slots, 7 bits each |
| slot_p_o | output | 24 | P field of all 8 slots, 3 bits each |
| slot_d_o | output | 56 | D field of all 8 slots, 7 bits each |

## Verification
A wrong preamble count or a missed start bit shows up as a word that is silently not stored, or as an unexpected store when a short preamble is accepted. Either is visible within about four system cycles of the stop bit's rising edge. A bit-order or field-slicing fault shows as wrong field values in the addressed slot on the same cycle as `load_o`. A slot-decode fault shows as a disturbed neighbouring slot. Coding and stop-bit faults show as `err_o` rising, or failing to rise, right after the offending edge.

// File: rtl/clksyn_rx_pkg.sv
package clksyn_rx_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_BITS   = 2'd2,
    ST_STOP   = 2'd3
  } rx_state_e;
endpackage

// File: rtl/clksyn_rx_sync.sv
module clksyn_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pclk_i,
  input  logic pdat_i,
  output logic rise_o,
  output logic fall_o,
  output logic data_o
);
  logic [STAGES-1:0] clk_sh, dat_sh;
  logic              clk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh   <= '0;
      dat_sh   <= '0;
      clk_prev <= 1'b0;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], pclk_i};
      dat_sh   <= {dat_sh[STAGES-2:0], pdat_i};
      clk_prev <= clk_sh[STAGES-1];
    end
  end

  assign rise_o = clk_sh[STAGES-1] & ~clk_prev;
  assign fall_o = ~clk_sh[STAGES-1] & clk_prev;
  assign data_o = dat_sh[STAGES-1];
endmodule

// File: rtl/clksyn_rx_fsm.sv
module clksyn_rx_fsm
  import clksyn_rx_pkg::*;
#(
  parameter int PRE_MIN = 5,
  parameter int WORD_W  = 24,
  parameter int BCNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              data_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o,
  output rx_state_e         state_o,
  output logic [BCNT_W-1:0] bit_cnt_o
);
  localparam int PCNT_W = $clog2(PRE_MIN + 1);

  rx_state_e         state;
  logic [PCNT_W-1:0] hi_cnt;
  logic [BCNT_W-1:0] bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              fall_val, fall_seen, err_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_LOCKED;
      hi_cnt    <= '0;
      bit_cnt   <= '0;
      shreg     <= '0;
      fall_val  <= 1'b0;
      fall_seen <= 1'b0;
      err_q     <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      unique case (state)
        ST_LOCKED: begin
          if (rise_i) begin
            if (data_i) begin
              if (hi_cnt != PCNT_W'(PRE_MIN)) hi_cnt <= hi_cnt + 1'b1;
            end else if (hi_cnt == PCNT_W'(PRE_MIN)) begin
              state  <= ST_ARMED;
              hi_cnt <= '0;
            end else begin
              hi_cnt <= '0;
            end
          end
        end
        ST_ARMED: begin
          if (rise_i) begin
            if (!data_i) begin
              state     <= ST_BITS;
              bit_cnt   <= '0;
              fall_seen <= 1'b0;
            end else begin
              // a high edge here counts toward the next preamble
              state  <= ST_LOCKED;
              hi_cnt <= PCNT_W'(1);
            end
          end
        end
        ST_BITS: begin
          if (fall_i) begin
            fall_val  <= data_i;
            fall_seen <= 1'b1;
          end else if (rise_i) begin
            if (!fall_seen || (fall_val == data_i)) begin
              err_q  <= 1'b1;
              state  <= ST_LOCKED;
              hi_cnt <= '0;
            end else begin
              shreg     <= {data_i, shreg[WORD_W-1:1]};
              fall_seen <= 1'b0;
              bit_cnt   <= bit_cnt + 1'b1;
              if (bit_cnt == BCNT_W'(WORD_W - 1)) state <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (rise_i) begin
            if (data_i) wr_q  <= 1'b1;
            else        err_q <= 1'b1;
            state  <= ST_LOCKED;
            hi_cnt <= '0;
          end
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  assign wr_o      = wr_q;
  assign word_o    = shreg;
  assign err_o     = err_q;
  assign state_o   = state;
  assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/clksyn_rx_regs.sv
module clksyn_rx_regs #(
  parameter int SEL_W    = 3,
  parameter int IDX_W    = 4,
  parameter int N_W      = 7,
  parameter int P_W      = 3,
  parameter int D_W      = 7,
  parameter int WORD_W   = SEL_W + IDX_W + N_W + P_W + D_W,
  parameter int SLOT_CNT = 1 << SEL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic                      load_o,
  output logic [SEL_W-1:0]          load_sel_o,
  output logic [SLOT_CNT*IDX_W-1:0] slot_idx_o,
  output logic [SLOT_CNT*N_W-1:0]   slot_n_o,
  output logic [SLOT_CNT*P_W-1:0]   slot_p_o,
  output logic [SLOT_CNT*D_W-1:0]   slot_d_o
);
  localparam int P_LSB = D_W;
  localparam int N_LSB = P_LSB + P_W;
  localparam int I_LSB = N_LSB + N_W;
  localparam int S_LSB = I_LSB + IDX_W;

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] f_idx;
  logic [N_W-1:0]   f_n;
  logic [P_W-1:0]   f_p;
  logic [D_W-1:0]   f_d;

  assign sel   = word_i[S_LSB +: SEL_W];
  assign f_idx = word_i[I_LSB +: IDX_W];
  assign f_n   = word_i[N_LSB +: N_W];
  assign f_p   = word_i[P_LSB +: P_W];
  assign f_d   = word_i[0 +: D_W];

  for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
    logic [IDX_W-1:0] idx_q;
    logic [N_W-1:0]   n_q;
    logic [P_W-1:0]   p_q;
    logic [D_W-1:0]   d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_q <= '0;
        n_q   <= '0;
        p_q   <= '0;
        d_q   <= '0;
      end else if (wr_i && (sel == SEL_W'(g))) begin
        idx_q <= f_idx;
        n_q   <= f_n;
        p_q   <= f_p;
        d_q   <= f_d;
      end
    end

    assign slot_idx_o[g*IDX_W +: IDX_W] = idx_q;
    assign slot_n_o[g*N_W +: N_W]       = n_q;
    assign slot_p_o[g*P_W +: P_W]       = p_q;
    assign slot_d_o[g*D_W +: D_W]       = d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o     <= 1'b0;
      load_sel_o <= '0;
    end else begin
      load_o <= wr_i;
      if (wr_i) load_sel_o <= sel;
    end
  end
endmodule

// File: rtl/clksyn_prog_rx.sv
module clksyn_prog_rx
  import clksyn_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_MIN     = 5,
  parameter int SEL_W       = 3,
  parameter int IDX_W       = 4,
  parameter int N_W         = 7,
  parameter int P_W         = 3,
  parameter int D_W         = 7,
  parameter int SLOT_CNT    = 1 << SEL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      prog_clk_i,
  input  logic                      prog_data_i,
  output logic                      load_o,
  output logic [SEL_W-1:0]          load_sel_o,
  output logic                      err_o,
  output logic [SLOT_CNT*IDX_W-1:0] slot_idx_o,
  output logic [SLOT_CNT*N_W-1:0]   slot_n_o,
  output logic [SLOT_CNT*P_W-1:0]   slot_p_o,
  output logic [SLOT_CNT*D_W-1:0]   slot_d_o
);
  localparam int WORD_W = SEL_W + IDX_W + N_W + P_W + D_W;
  localparam int BCNT_W = $clog2(WORD_W + 1);

  logic              s_rise, s_fall, s_data;
  logic              wr;
  logic [WORD_W-1:0] word;
  rx_state_e         fsm_state;
  logic [BCNT_W-1:0] bit_cnt;

  clksyn_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pclk_i (prog_clk_i),
    .pdat_i (prog_data_i),
    .rise_o (s_rise),
    .fall_o (s_fall),
    .data_o (s_data)
  );

  clksyn_rx_fsm #(
    .PRE_MIN (PRE_MIN),
    .WORD_W  (WORD_W),
    .BCNT_W  (BCNT_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (s_rise),
    .fall_i    (s_fall),
    .data_i    (s_data),
    .wr_o      (wr),
    .word_o    (word),
    .err_o     (err_o),
    .state_o   (fsm_state),
    .bit_cnt_o (bit_cnt)
  );

  clksyn_rx_regs #(
    .SEL_W    (SEL_W),
    .IDX_W    (IDX_W),
    .N_W      (N_W),
    .P_W      (P_W),
    .D_W      (D_W),
    .WORD_W   (WORD_W),
    .SLOT_CNT (SLOT_CNT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .word_i     (word),
    .load_o     (load_o),
    .load_sel_o (load_sel_o),
    .slot_idx_o (slot_idx_o),
    .slot_n_o   (slot_n_o),
    .slot_p_o   (slot_p_o),
    .slot_d_o   (slot_d_o)
  );
endmodule

// File: rtl/clksyn_prog_rx_chk.sv
module clksyn_prog_rx_chk
  import clksyn_rx_pkg::*;
#(
  parameter int SLOTS_W = 168,
  parameter int WORD_W  = 24,
  parameter int BCNT_W  = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               err_i,
  input logic [SLOTS_W-1:0] slots_i,
  input rx_state_e          state_i,
  input logic [BCNT_W-1:0]  bit_cnt_i
);
  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !load_i);

  a_r8_locked_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (state_i == ST_LOCKED));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  a_r10_slots_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |-> $stable(slots_i));

  a_r4_bitcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= BCNT_W'(WORD_W));

  a_r5_err_returns_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> (state_i == ST_LOCKED));
endmodule

bind clksyn_prog_rx clksyn_prog_rx_chk #(
  .SLOTS_W (SLOT_CNT * (IDX_W + N_W + P_W + D_W)),
  .WORD_W  (WORD_W),
  .BCNT_W  (BCNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_o),
  .err_i     (err_o),
  .slots_i   ({slot_idx_o, slot_n_o, slot_p_o, slot_d_o}),
  .state_i   (fsm_state),
  .bit_cnt_i (bit_cnt)
);

// File: tb/tb_clksyn_prog_rx.sv
module tb_clksyn_prog_rx;
  localparam int SLOTS = 8;
  localparam int HOLD  = 4;

  typedef struct packed {
    logic [2:0] sel;
    logic [3:0] idx;
    logic [6:0] n;
    logic [2:0] p;
    logic [6:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk = 1'b0;
  logic        pdat = 1'b0;
  logic        load_o, err_o;
  logic [2:0]  load_sel_o;
  logic [31:0] slot_idx_o;
  logic [55:0] slot_n_o, slot_d_o;
  logic [23:0] slot_p_o;

  clksyn_prog_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_clk_i(pclk), .prog_data_i(pdat),
    .load_o(load_o), .load_sel_o(load_sel_o), .err_o(err_o),
    .slot_idx_o(slot_idx_o), .slot_n_o(slot_n_o),
    .slot_p_o(slot_p_o), .slot_d_o(slot_d_o)
  );

  always #10 clk = ~clk;

  item_t exp_q[$];
  item_t model[SLOTS];
  int    checks = 0, fails = 0;
  bit    err_exp = 1'b0;
  bit    prev_load = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_slots(input string req);
    for (int g = 0; g < SLOTS; g++) begin
      check(slot_idx_o[g*4 +: 4] == model[g].idx, req, slot_idx_o[g*4 +: 4], model[g].idx);
      check(slot_n_o[g*7 +: 7]   == model[g].n,   req, slot_n_o[g*7 +: 7],   model[g].n);
      check(slot_p_o[g*3 +: 3]   == model[g].p,   req, slot_p_o[g*3 +: 3],   model[g].p);
      check(slot_d_o[g*7 +: 7]   == model[g].d,   req, slot_d_o[g*7 +: 7],   model[g].d);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_o) begin
        if (prev_load) check(1'b0, "R8 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected load", load_sel_o, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(load_sel_o == e.sel, "R8 load_sel", load_sel_o, e.sel);
          model[e.sel] = e;
          compare_slots("R4 R7 R10 slot contents");
        end
      end
      prev_load = load_o;
    end else begin
      prev_load = 1'b0;
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
    $finish;
  end

  task automatic pin(input logic c, input logic d);
    pclk = c;
    pdat = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    for (int g = 0; g < SLOTS; g++) model[g] = '0;
    err_exp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(load_o == 1'b0, "R1 load low after reset", load_o, 0);
    check(err_o == 1'b0, "R1 err low after reset", err_o, 0);
    compare_slots("R1 slots zero after reset");
  endtask

  task automatic send_frame(input item_t w, input int npre, input bit start_v,
                            input int bad_idx, input bit stop_v, input bit store,
                            input string req);
    logic [23:0] word;
    word = w;
    if (store) exp_q.push_back(w);
    // preamble and unlock edge
    pin(0, 0);
    pin(0, 1);
    for (int i = 0; i < npre; i++) begin
      pin(1, 1);
      pin(0, 1);
    end
    pin(0, 0);
    pin(1, 0);
    // start bit
    pin(0, start_v);
    pin(1, start_v);
    // data bits, LSB first
    for (int i = 0; i < 24; i++) begin
      logic b, f;
      b = word[i];
      f = (i == bad_idx) ? b : ~b;
      pin(1, f);
      pin(0, f);
      pin(0, b);
      pin(1, b);
    end
    // stop bit
    pin(1, stop_v);
    pin(0, stop_v);
    pin(1, stop_v);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, {req, " store count"}, exp_q.size(), 0);
    check(err_o == err_exp, {req, " err flag"}, err_o, err_exp);
    compare_slots({req, " slots after frame"});
  endtask

  initial begin
    pclk = 1'b0;
    pdat = 1'b0;
    do_reset();

    send_frame({3'd2, 4'hA, 7'h5B, 3'd6, 7'h21}, 5, 1'b0, -1, 1'b1, 1'b1, "R2 R4 minimum preamble");
    send_frame({3'd5, 4'h3, 7'h7F, 3'd1, 7'h00}, 9, 1'b0, -1, 1'b1, 1'b1, "R2 long preamble");
    send_frame({3'd2, 4'h4, 7'h12, 3'd3, 7'h7E}, 6, 1'b0, -1, 1'b1, 1'b1, "R10 overwrite slot");
    send_frame(24'h555555, 4, 1'b0, -1, 1'b1, 1'b0, "R2 short preamble ignored");
    send_frame(24'h555555, 5, 1'b1, -1, 1'b1, 1'b0, "R3 high start bit ignored");

    err_exp = 1'b1;
    send_frame({3'd7, 4'h9, 7'h33, 3'd5, 7'h44}, 5, 1'b0, -1, 1'b0, 1'b0, "R6 missing stop");

    do_reset();
    check(err_o == 1'b0, "R1 err cleared by reset", err_o, 0);

    err_exp = 1'b1;
    send_frame(24'h555555, 5, 1'b0, 3, 1'b1, 1'b0, "R5 complement violation");
    send_frame({3'd0, 4'h6, 7'h0F, 3'd2, 7'h55}, 5, 1'b0, -1, 1'b1, 1'b1, "R9 store after error");
    send_frame(24'hFFFFFF, 5, 1'b0, -1, 1'b1, 1'b1, "R7 all ones word");
    send_frame(24'h000000, 5, 1'b0, -1, 1'b1, 1'b1, "R7 all zeros word");

    report();
    $finish;
  end
endmodule